// File: doc/BRIEF.md
# Block-Write Per-Bit Enable Combiner

This block produces the bit-level write enables for a 32-bit-wide graphics DRAM array. A normal write gets one 32-bit enable. A block write gets one 32-bit enable for each of eight adjacent columns.

Each enable bit is formed from three sources:
- the four byte-lane strobes, where a strobe of 1 suppresses its lane;
- a 32-bit write mask register;
- for block writes, a column mask carried on the data inputs.

The write mask register is loaded from the data inputs by a separate load command. It only takes part when the addressed bank was opened in masked mode. Otherwise its term counts as all ones.

All results appear on the clock edge after the command, together with a one-cycle valid strobe and the target column. For a block write, the target column is aligned down to the first column of its eight-column group. The array and the color datapath sit downstream and consume these enables.

Top module: `wmc_top`

## Requirements
- R1: After reset the mask register holds all ones, so a masked-mode write with all strobes at 0 enables all 32 bits.
- R2: When `load_mask_i` is 1, the mask register takes `dq_i` at the clock edge. At all other times it keeps its value. Its effect is observed through later masked-mode writes.
- R3: A normal write (`wr_i`=1, `blk_wr_i`=0) gives, one cycle later, `valid_o`=1, `blk_o`=0 and `col_o`=`col_i`. Bit b of `wr_en_o` is 1 only if strobe `dqm_i[b/8]` is 0 and mask term bit b is 1.
- R4: With `masked_i`=0 the mask term is all ones, whatever the mask register holds.
- R5: A block write gives, one cycle later, `col_en_o[c*32+b]` = (`dqm_i[b/8]`==0) AND `dq_i[(b/8)*8+c]` AND mask term bit b, for c in 0..7 and b in 0..31. In the same cycle `wr_en_o` is 0.
- R6: On a block write, `col_o` is `col_i` with its three low bits cleared.
- R7: When `wr_i` and `blk_wr_i` are both 1, the block write is performed.
- R8: When a load and a write fall in the same cycle, that write uses the mask value from before the load. The next write uses the loaded value.
- R9: In a cycle following no write command, `valid_o`, `blk_o`, `col_o`, `wr_en_o` and `col_en_o` are all 0. This also holds during reset.
- R10: A strobe of 1 in `dqm_i[l]` clears bits l*8 to l*8+7 of every enable produced by that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_mask_i | input | 1 | Load the mask register from dq_i |
| wr_i | input | 1 | Normal write command |
| blk_wr_i | input | 1 | Block write command |
| masked_i | input | 1 | Addressed bank was opened in masked mode |
| col_i | input | 8 | Column address at the command |
| dqm_i | input | 4 | Byte strobes, 1 suppresses the lane |
| dq_i | input | 32 | Data inputs: mask source or column mask |
| valid_o | output | 1 | Enables valid this cycle |
| blk_o | output | 1 | Result is a block write |
| col_o | output | 8 | Target column, aligned for block writes |
| wr_en_o | output | 32 | Normal write bit enable |
| col_en_o | output | 256 | Block write enables, 32 bits per column |

## Verification
The mask load and a write can fall in the same cycle, and their ordering is the delicate case. The bench drives `load_mask_i` together with a normal or block write. Some of these writes carry a new mask on `dq_i` that differs from the stored one.

The expected enable for that write is built from the old mask. The write in the following cycle is built from the new one. The behavioural model, which is compared on every clock, tracks both.

Random phases place loads and writes in the same cycle repeatedly, with `masked_i` toggling between them.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned BLK_COLS = 8;
  localparam int unsigned COL_W    = 8;
endpackage

// File: rtl/wmc_mask_reg.sv
module wmc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '1;
    else if (load_i) q_o <= d_i;
  end

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R2
endmodule

// File: rtl/wmc_lane.sv
module wmc_lane #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned BLK_COLS = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         dqm_i,
  input  logic [LANE_W-1:0]            dq_i,
  input  logic [LANE_W-1:0]            mterm_i,
  output logic [LANE_W-1:0]            norm_en_o,
  output logic [BLK_COLS*LANE_W-1:0]   blk_en_o
);
  logic [LANE_W-1:0] lane_pass;
  assign lane_pass = dqm_i ? '0 : mterm_i;
  assign norm_en_o = lane_pass;

  // one DQ bit of this lane opens one column of the block
  for (genvar c = 0; c < BLK_COLS; c++) begin : g_col
    assign blk_en_o[c*LANE_W +: LANE_W] = dq_i[c] ? lane_pass : '0;
  end

  initial begin
    assert (LANE_W >= BLK_COLS) else $error("lane narrower than block");
  end

  AST_DQM_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_i |-> (blk_en_o == '0 && norm_en_o == '0)); // R10
endmodule

// File: rtl/wmc_top.sv
module wmc_top
  import wmc_pkg::*;
#(
  parameter int unsigned DATA_W_P   = DATA_W,
  parameter int unsigned LANE_W_P   = LANE_W,
  parameter int unsigned BLK_COLS_P = BLK_COLS,
  parameter int unsigned COL_W_P    = COL_W,
  localparam int unsigned NLANES    = DATA_W_P / LANE_W_P,
  localparam int unsigned BLK_SH    = $clog2(BLK_COLS_P),
  localparam int unsigned CEN_W     = BLK_COLS_P * DATA_W_P
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_mask_i,
  input  logic                wr_i,
  input  logic                blk_wr_i,
  input  logic                masked_i,
  input  logic [COL_W_P-1:0]  col_i,
  input  logic [NLANES-1:0]   dqm_i,
  input  logic [DATA_W_P-1:0] dq_i,
  output logic                valid_o,
  output logic                blk_o,
  output logic [COL_W_P-1:0]  col_o,
  output logic [DATA_W_P-1:0] wr_en_o,
  output logic [CEN_W-1:0]    col_en_o
);
  logic [DATA_W_P-1:0] mask_q, mterm, norm_en;
  logic [CEN_W-1:0]    blk_en;

  wmc_mask_reg #(.W(DATA_W_P)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_mask_i),
    .d_i   (dq_i),
    .q_o   (mask_q)
  );

  // register read before load: same-cycle write sees old mask
  assign mterm = masked_i ? mask_q : '1;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic [BLK_COLS_P*LANE_W_P-1:0] lane_blk;
    wmc_lane #(.LANE_W(LANE_W_P), .BLK_COLS(BLK_COLS_P)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dqm_i    (dqm_i[l]),
      .dq_i     (dq_i[l*LANE_W_P +: LANE_W_P]),
      .mterm_i  (mterm[l*LANE_W_P +: LANE_W_P]),
      .norm_en_o(norm_en[l*LANE_W_P +: LANE_W_P]),
      .blk_en_o (lane_blk)
    );
    for (genvar c = 0; c < BLK_COLS_P; c++) begin : g_map
      assign blk_en[c*DATA_W_P + l*LANE_W_P +: LANE_W_P] =
        lane_blk[c*LANE_W_P +: LANE_W_P];
    end
  end

  logic               any_wr, norm_wr;
  logic [COL_W_P-1:0] base_col;
  assign any_wr   = wr_i | blk_wr_i;
  assign norm_wr  = wr_i & ~blk_wr_i;
  assign base_col = {col_i[COL_W_P-1:BLK_SH], {BLK_SH{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      blk_o    <= 1'b0;
      col_o    <= '0;
      wr_en_o  <= '0;
      col_en_o <= '0;
    end else begin
      valid_o  <= any_wr;
      blk_o    <= blk_wr_i;
      col_o    <= blk_wr_i ? base_col : (wr_i ? col_i : '0);
      wr_en_o  <= norm_wr  ? norm_en : '0;
      col_en_o <= blk_wr_i ? blk_en  : '0;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |=> valid_o); // R3
  AST_UNMASKED_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_wr && !masked_i && dqm_i == '0) |=> wr_en_o == '1); // R4
  AST_BASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_o |-> col_o[BLK_SH-1:0] == '0); // R6
  AST_BLK_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_wr_i |=> (blk_o && wr_en_o == '0)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!blk_o && col_o == '0 && wr_en_o == '0 && col_en_o == '0)); // R9
endmodule

// File: tb/tb_wmc_top.sv
module tb_wmc_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_mask_i = 1'b0, wr_i = 1'b0, blk_wr_i = 1'b0, masked_i = 1'b0;
  logic [7:0]   col_i = '0;
  logic [3:0]   dqm_i = '0;
  logic [31:0]  dq_i = '0;
  logic         valid_o, blk_o;
  logic [7:0]   col_o;
  logic [31:0]  wr_en_o;
  logic [255:0] col_en_o;

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R9 reset", exp_tag = "R9 reset";

  always #10 clk_i = ~clk_i;

  wmc_top dut (.*);

  // behavioural reference
  logic [31:0]  m_mask;
  logic         e_valid, e_blk;
  logic [7:0]   e_col;
  logic [31:0]  e_wr;
  logic [255:0] e_cen;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = 32'hFFFF_FFFF;
      e_valid = 0; e_blk = 0; e_col = 0; e_wr = 0; e_cen = 0;
      exp_tag = cur_tag;
    end else begin
      logic [31:0] mt;
      mt = masked_i ? m_mask : 32'hFFFF_FFFF;
      e_valid = wr_i || blk_wr_i;
      e_blk = blk_wr_i;
      e_wr = 0; e_cen = 0; e_col = 0;
      if (blk_wr_i) begin
        e_col = col_i & 8'hF8;
        for (int c = 0; c < 8; c++)
          for (int b = 0; b < 32; b++)
            e_cen[c*32+b] = !dqm_i[b/8] && dq_i[(b/8)*8+c] && mt[b];
      end else if (wr_i) begin
        e_col = col_i;
        for (int b = 0; b < 32; b++) e_wr[b] = !dqm_i[b/8] && mt[b];
      end
      if (load_mask_i) m_mask = dq_i;
      exp_tag = cur_tag;
    end
  end

  task automatic check();
    n_chk++;
    if (valid_o !== e_valid || blk_o !== e_blk || col_o !== e_col ||
        wr_en_o !== e_wr || col_en_o !== e_cen) begin
      n_bad++;
      $display("FAIL %s: got v=%0b b=%0b col=%h wr=%h cen=%h exp v=%0b b=%0b col=%h wr=%h cen=%h",
               exp_tag, valid_o, blk_o, col_o, wr_en_o, col_en_o,
               e_valid, e_blk, e_col, e_wr, e_cen);
    end
  endtask

  task automatic step(string tag, logic ld, logic w, logic bw, logic m,
                      logic [7:0] col, logic [3:0] dqm, logic [31:0] dq);
    @(negedge clk_i);
    check();
    cur_tag = tag;
    load_mask_i = ld; wr_i = w; blk_wr_i = bw; masked_i = m;
    col_i = col; dqm_i = dqm; dq_i = dq;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 8'h00, 4'h0, 32'h0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check();  // R9 reset state
    check();
    rst_ni = 1'b1;
    step("R1 reset mask all ones", 0, 1, 0, 1, 8'h11, 4'h0, 32'h0);
    step("R2 load mask", 1, 0, 0, 0, 8'h00, 4'h0, 32'h0F0F_00FF);
    step("R9 idle after load", 0, 0, 0, 0, 8'h00, 4'h0, 32'h0);
    step("R2 masked write uses loaded mask", 0, 1, 0, 1, 8'h22, 4'h0, 32'h0);
    step("R4 unmasked ignores register", 0, 1, 0, 0, 8'h23, 4'h0, 32'h0);
    step("R10 dqm lanes 0 and 2", 0, 1, 0, 0, 8'h24, 4'b0101, 32'h0);
    step("R5 block write", 0, 0, 1, 1, 8'h2D, 4'h0, 32'h8142_A55A);
    step("R6 block base align", 0, 0, 1, 0, 8'hFF, 4'h0, 32'hFFFF_FFFF);
    step("R10 block dqm lane 3", 0, 0, 1, 0, 8'h07, 4'b1000, 32'hFFFF_FFFF);
    step("R7 both commands", 0, 1, 1, 0, 8'h45, 4'h0, 32'h0101_0101);
    step("R8 load with write", 1, 1, 0, 1, 8'h30, 4'h0, 32'h1234_5678);
    step("R8 next write sees new mask", 0, 1, 0, 1, 8'h31, 4'h0, 32'h0);
    step("R8 load with block write", 1, 0, 1, 1, 8'h38, 4'h0, 32'hFFFF_FFFF);
    step("R8 block after load", 0, 0, 1, 1, 8'h38, 4'h0, 32'hFFFF_FFFF);
    idle("R9 idle");
    idle("R9 idle");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] k;
      k = 4'($urandom);
      step("R3 R5 random", k[0], k[1], k[2] & k[3], 1'($urandom),
           8'($urandom), 4'($urandom) & 4'($urandom), $urandom);
    end
    idle("R9 final idle");
    idle("R9 final idle");
    @(negedge clk_i);
    check();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule